// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block is the home-node directory controller for a small group of memory blocks. For each block it tracks which processors hold a cached copy, using one presence bit per processor, and whether exactly one processor holds the block modified, using a single dirty bit. A block is therefore always in one of three conditions: uncached, held by one or more readers, or held by exactly one writer.

Processors send read and write requests tagged with a processor ID and a block index. The controller decides which caches must be told about each request. It sends recall, invalidate or recall-and-invalidate messages one at a time, and counts the acknowledgements that come back. Recalled data is written to memory through a word interface with one-cycle access. The controller then returns data, or a write grant with data, to the requester. Each channel uses a valid/ready handshake. Only one transaction is in flight at a time, so any new request waits with its ready low until the current one completes.

Top module: `fmap_dir_ctrl`

## Requirements
- R1: After reset every block is uncached. `req_ready_o` is high, and `msg_valid_o`, `rsp_valid_o` and `ack_ready_o` are low.
- R2: A read of a block that is not dirty is answered with the memory word at address = block index, with `rsp_write_o`=0. No coherence message is sent, and the requester's presence bit is set.
- R3: A read of a block that another processor holds dirty sends a recall (`msg_kind_o`=0) to that owner. The acknowledged data is written to memory at the block's address and returned to the requester. The block then becomes clean, and both the old owner and the requester are recorded as sharers.
- R4: A write to a block that is not dirty sends an invalidate (`msg_kind_o`=1) to every sharer except the requester, in ascending processor order. The grant (`rsp_write_o`=1, data read from memory) is withheld until every invalidate has been acknowledged.
- R5: A write to a block that another processor holds dirty sends a recall-and-invalidate (`msg_kind_o`=2) to the owner. The recalled data is written to memory and returned with the grant. Afterwards the requester is the sole dirty owner.
- R6: A read or write from the processor that already owns a dirty block is served from memory with no messages, and the block's directory state is left unchanged.
- R7: From the time a request is accepted until its response is taken, `req_ready_o` stays low.
- R8: While `msg_valid_o` is high and `msg_ready_i` is low, the message destination and kind hold steady.
- R9: While `rsp_valid_o` is high and `rsp_ready_i` is low, the response fields hold steady.
- R10: `ack_ready_o` is high only while at least one sent message has not yet been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high |
| req_write_i | input | 1 | 1 = write request, 0 = read |
| req_pid_i | input | PID_W | Requesting processor |
| req_blk_i | input | BLK_W | Block index |
| msg_valid_o | output | 1 | Coherence message valid |
| msg_ready_i | input | 1 | Message taken by the network |
| msg_kind_o | output | 2 | 0 recall, 1 invalidate, 2 recall-and-invalidate |
| msg_dest_o | output | PID_W | Target processor |
| msg_blk_o | output | BLK_W | Block concerned |
| ack_valid_i | input | 1 | Acknowledgement valid |
| ack_ready_o | output | 1 | Acknowledgement accepted when high |
| ack_data_i | input | DATA_W | Data carried by a recall acknowledgement |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | BLK_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after a read strobe |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_write_o | output | 1 | 1 = write grant, 0 = read data |
| rsp_pid_o | output | PID_W | Processor the response is for |
| rsp_data_o | output | DATA_W | Returned block data |

## Verification
The bench builds a block with three sharers and then writes it from a fourth processor. This checks that invalidates go out in ascending order and skip the requester. A scheduler that let the grant through early would raise `rsp_valid_o` while an acknowledgement was still outstanding. A read of a dirty block is followed by a write from a third processor. That write must invalidate both the old owner and the reader, so a design that dropped the owner's presence bit on a downgrade would skip one invalidate. Requests from the current owner must produce no traffic, and a design that misread ownership would emit a spurious recall. The bench also checks that memory holds the recalled word, and that messages and responses stay frozen under backpressure.

// File: rtl/fmap_dir_pkg.sv
package fmap_dir_pkg;
  typedef enum logic [1:0] {
    MSG_RECALL     = 2'd0,
    MSG_INVAL      = 2'd1,
    MSG_RECALL_INV = 2'd2
  } msg_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_COH,
    S_MEMRD,
    S_MEMCAP,
    S_MEMWR,
    S_RSP
  } ctrl_state_e;
endpackage

// File: rtl/fmap_dir_store.sv
module fmap_dir_store #(
  parameter int NPROC = 8,
  parameter int NBLK  = 16,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] rd_blk_i,
  output logic [NPROC-1:0] rd_pres_o,
  output logic             rd_dirty_o,
  input  logic             wr_en_i,
  input  logic [BLK_W-1:0] wr_blk_i,
  input  logic [NPROC-1:0] wr_pres_i,
  input  logic             wr_dirty_i
);
  logic [NPROC-1:0] pres_q  [NBLK];
  logic [NBLK-1:0]  dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NBLK; b++) pres_q[b] <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      pres_q[wr_blk_i]  <= wr_pres_i;
      dirty_q[wr_blk_i] <= wr_dirty_i;
    end
  end

  assign rd_pres_o  = pres_q[rd_blk_i];
  assign rd_dirty_o = dirty_q[rd_blk_i];

  // R5: a dirty entry names exactly one owner
  p_dirty_single_owner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_dirty_i |-> $onehot(wr_pres_i));
endmodule

// File: rtl/fmap_inv_sched.sv
module fmap_inv_sched #(
  parameter int NPROC = 8,
  localparam int PID_W = $clog2(NPROC),
  localparam int CNT_W = $clog2(NPROC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NPROC-1:0] mask_i,
  input  logic             send_i,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [PID_W-1:0] dest_o,
  output logic             outstanding_o,
  output logic             done_o
);
  logic [NPROC-1:0] pend_q;
  logic [CNT_W-1:0] cnt_q;

  // lowest pending processor goes first
  always_comb begin
    dest_o = '0;
    for (int p = NPROC - 1; p >= 0; p--)
      if (pend_q[p]) dest_o = PID_W'(p);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      pend_q <= mask_i;
      cnt_q  <= '0;
    end else begin
      if (send_i) pend_q[dest_o] <= 1'b0;
      cnt_q <= cnt_q + CNT_W'(send_i) - CNT_W'(ack_i);
    end
  end

  assign pend_o        = |pend_q;
  assign outstanding_o = cnt_q != '0;
  assign done_o        = !pend_o && !outstanding_o;

  p_send_needs_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_i |-> pend_o);
  p_ack_needs_outstanding_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> outstanding_o);
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NPROC));
endmodule

// File: rtl/fmap_dir_ctrl.sv
module fmap_dir_ctrl
  import fmap_dir_pkg::*;
#(
  parameter int NPROC  = 8,
  parameter int NBLK   = 16,
  parameter int DATA_W = 32,
  localparam int PID_W = $clog2(NPROC),
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [PID_W-1:0]  req_pid_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [1:0]        msg_kind_o,
  output logic [PID_W-1:0]  msg_dest_o,
  output logic [BLK_W-1:0]  msg_blk_o,
  input  logic              ack_valid_i,
  output logic              ack_ready_o,
  input  logic [DATA_W-1:0] ack_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_write_o,
  output logic [PID_W-1:0]  rsp_pid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  ctrl_state_e      state_q, state_d;
  logic             wr_q, need_data_q, self_q;
  logic [PID_W-1:0] pid_q;
  logic [BLK_W-1:0] blk_q;
  msg_kind_e        kind_q, kind_d;
  logic [NPROC-1:0] pres_q;
  logic [DATA_W-1:0] data_q;

  logic [NPROC-1:0] rd_pres, req_oh, pid_oh, load_mask, new_pres;
  logic             rd_dirty, req_fire, msg_fire, ack_fire, rsp_fire;
  logic             owner_self, load, sched_pend, sched_out, sched_done, new_dirty;
  logic [PID_W-1:0] sched_dest;

  fmap_dir_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
    .clk_i, .rst_ni,
    .rd_blk_i   (req_blk_i),
    .rd_pres_o  (rd_pres),
    .rd_dirty_o (rd_dirty),
    .wr_en_i    (rsp_fire),
    .wr_blk_i   (blk_q),
    .wr_pres_i  (new_pres),
    .wr_dirty_i (new_dirty)
  );

  fmap_inv_sched #(.NPROC(NPROC)) u_sched (
    .clk_i, .rst_ni,
    .load_i        (load),
    .mask_i        (load_mask),
    .send_i        (msg_fire),
    .ack_i         (ack_fire),
    .pend_o        (sched_pend),
    .dest_o        (sched_dest),
    .outstanding_o (sched_out),
    .done_o        (sched_done)
  );

  assign req_oh     = {{(NPROC-1){1'b0}}, 1'b1} << req_pid_i;
  assign pid_oh     = {{(NPROC-1){1'b0}}, 1'b1} << pid_q;
  assign owner_self = rd_dirty && |(rd_pres & req_oh);

  assign req_ready_o = state_q == S_IDLE;
  assign req_fire    = req_valid_i && req_ready_o;
  assign msg_valid_o = state_q == S_COH && sched_pend;
  assign msg_fire    = msg_valid_o && msg_ready_i;
  assign ack_ready_o = state_q == S_COH && sched_out;
  assign ack_fire    = ack_valid_i && ack_ready_o;
  assign rsp_valid_o = state_q == S_RSP;
  assign rsp_fire    = rsp_valid_o && rsp_ready_i;

  // decide coherence action at acceptance
  always_comb begin
    load      = 1'b0;
    load_mask = '0;
    kind_d    = MSG_INVAL;
    if (req_fire) begin
      if (rd_dirty && !owner_self) begin
        load      = 1'b1;
        load_mask = rd_pres;
        kind_d    = req_write_i ? MSG_RECALL_INV : MSG_RECALL;
      end else if (req_write_i && !rd_dirty && |(rd_pres & ~req_oh)) begin
        load      = 1'b1;
        load_mask = rd_pres & ~req_oh;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (req_fire) state_d = load ? S_COH : S_MEMRD;
      S_COH:    if (sched_done) state_d = need_data_q ? S_MEMWR : S_MEMRD;
      S_MEMRD:  state_d = S_MEMCAP;
      S_MEMCAP: state_d = S_RSP;
      S_MEMWR:  state_d = S_RSP;
      S_RSP:    if (rsp_ready_i) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      wr_q        <= 1'b0;
      need_data_q <= 1'b0;
      self_q      <= 1'b0;
      pid_q       <= '0;
      blk_q       <= '0;
      kind_q      <= MSG_INVAL;
      pres_q      <= '0;
      data_q      <= '0;
    end else begin
      state_q <= state_d;
      if (req_fire) begin
        wr_q        <= req_write_i;
        pid_q       <= req_pid_i;
        blk_q       <= req_blk_i;
        kind_q      <= kind_d;
        pres_q      <= rd_pres;
        self_q      <= owner_self;
        need_data_q <= rd_dirty && !owner_self;
      end
      if (ack_fire && need_data_q) data_q <= ack_data_i;
      if (state_q == S_MEMCAP)     data_q <= mem_rdata_i;
    end
  end

  assign msg_kind_o = kind_q;
  assign msg_dest_o = sched_dest;
  assign msg_blk_o  = blk_q;

  assign mem_req_o   = state_q == S_MEMRD || state_q == S_MEMWR;
  assign mem_we_o    = state_q == S_MEMWR;
  assign mem_addr_o  = blk_q;
  assign mem_wdata_o = data_q;

  assign rsp_write_o = wr_q;
  assign rsp_pid_o   = pid_q;
  assign rsp_data_o  = data_q;

  // directory update when the response is taken
  always_comb begin
    if (self_q) begin
      new_pres  = pres_q;
      new_dirty = 1'b1;
    end else if (wr_q) begin
      new_pres  = pid_oh;
      new_dirty = 1'b1;
    end else begin
      new_pres  = pres_q | pid_oh;
      new_dirty = 1'b0;
    end
  end

  p_grant_after_acks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> sched_done);
  p_no_self_inval_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_kind_o == MSG_INVAL |-> msg_dest_o != pid_q);
  p_stall_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o || ack_ready_o |-> !req_ready_o);
  p_msg_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_dest_o) && $stable(msg_kind_o));
  p_rsp_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_pid_o));
  p_recall_writes_mem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> need_data_q);
endmodule

// File: tb/fmap_dir_ctrl_tb.sv
module fmap_dir_ctrl_tb;
  localparam int NPROC = 8, NBLK = 16, DATA_W = 32;
  localparam int PID_W = $clog2(NPROC), BLK_W = $clog2(NBLK);

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [PID_W-1:0] req_pid = '0;
  logic [BLK_W-1:0] req_blk = '0;
  logic msg_ready = 0, ack_valid = 0, rsp_ready = 0;
  logic [DATA_W-1:0] ack_data = '0;
  logic req_ready_o, msg_valid_o, ack_ready_o, mem_req_o, mem_we_o, rsp_valid_o, rsp_write_o;
  logic [1:0] msg_kind_o;
  logic [PID_W-1:0] msg_dest_o, rsp_pid_o;
  logic [BLK_W-1:0] msg_blk_o, mem_addr_o;
  logic [DATA_W-1:0] mem_wdata_o, rsp_data_o, mem_rdata;
  logic [DATA_W-1:0] mem [NBLK];

  int checks = 0, errors = 0, msg_seen = 0;

  fmap_dir_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o, .req_write_i(req_write),
    .req_pid_i(req_pid), .req_blk_i(req_blk),
    .msg_valid_o, .msg_ready_i(msg_ready), .msg_kind_o, .msg_dest_o, .msg_blk_o,
    .ack_valid_i(ack_valid), .ack_ready_o, .ack_data_i(ack_data),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i(mem_rdata),
    .rsp_valid_o, .rsp_ready_i(rsp_ready), .rsp_write_o, .rsp_pid_o, .rsp_data_o
  );

  // memory model: one-cycle read
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) mem[b] <= 32'hA000_0000 + b;
      mem_rdata <= '0;
    end else if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else mem_rdata <= mem[mem_addr_o];
    end
  end

  always @(posedge clk) if (rst_n && msg_valid_o) msg_seen <= msg_seen + 1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic w, input int pid, input int blk);
    @(negedge clk);
    req_valid = 1; req_write = w; req_pid = PID_W'(pid); req_blk = BLK_W'(blk);
    for (int t = 0; t < 100 && !req_ready_o; t++) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic get_msg(input int kind, input int dest, input int blk, input string tag);
    int t;
    for (t = 0; t < 100 && !msg_valid_o; t++) @(negedge clk);
    chk(msg_valid_o, {tag, " msg valid"}, 32'(msg_valid_o), 1);
    chk(msg_kind_o == 2'(kind), {tag, " msg kind"}, 32'(msg_kind_o), 32'(kind));
    chk(msg_dest_o == PID_W'(dest), {tag, " msg dest"}, 32'(msg_dest_o), 32'(dest));
    chk(msg_blk_o == BLK_W'(blk), {tag, " msg blk"}, 32'(msg_blk_o), 32'(blk));
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic send_ack(input logic [31:0] d);
    @(negedge clk);
    ack_valid = 1; ack_data = d;
    for (int t = 0; t < 100 && !ack_ready_o; t++) @(negedge clk);
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic get_rsp(input logic w, input int pid, input logic [31:0] d, input string tag);
    for (int t = 0; t < 100 && !rsp_valid_o; t++) @(negedge clk);
    chk(rsp_valid_o, {tag, " rsp valid"}, 32'(rsp_valid_o), 1);
    chk(rsp_write_o == w, {tag, " rsp kind"}, 32'(rsp_write_o), 32'(w));
    chk(rsp_pid_o == PID_W'(pid), {tag, " rsp pid"}, 32'(rsp_pid_o), 32'(pid));
    chk(rsp_data_o == d, {tag, " rsp data"}, rsp_data_o, d);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic quiet_read(input int pid, input int blk, input logic [31:0] d, input string tag);
    int m0 = msg_seen;
    do_req(0, pid, blk);
    get_rsp(0, pid, d, tag);
    chk(msg_seen == m0, {tag, " no messages"}, 32'(msg_seen - m0), 0);
  endtask

  task automatic t_reset();
    chk(req_ready_o, "R1 ready", 32'(req_ready_o), 1);
    chk(!msg_valid_o && !rsp_valid_o, "R1 idle outputs", 32'({msg_valid_o, rsp_valid_o}), 0);
    chk(!ack_ready_o, "R10 no ack ready when idle", 32'(ack_ready_o), 0);
  endtask

  task automatic t_clean_reads();
    quiet_read(2, 3, 32'hA000_0003, "R2 first reader");
    quiet_read(5, 3, 32'hA000_0003, "R2 second reader");
  endtask

  task automatic t_write_shared();
    do_req(1, 5, 3);
    for (int t = 0; t < 20 && !msg_valid_o; t++) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(msg_valid_o && msg_dest_o == 2 && msg_kind_o == 1, "R8 msg held",
          32'({msg_valid_o, msg_kind_o, msg_dest_o}), 32'({1'b1, 2'd1, 3'd2}));
    end
    get_msg(1, 2, 3, "R4 inval excl requester");
    for (int i = 0; i < 3; i++) begin
      chk(!rsp_valid_o, "R4 grant withheld", 32'(rsp_valid_o), 0);
      chk(!req_ready_o, "R7 stalled", 32'(req_ready_o), 0);
      chk(ack_ready_o, "R10 ack ready", 32'(ack_ready_o), 1);
      @(negedge clk);
    end
    send_ack(32'h0);
    get_rsp(1, 5, 32'hA000_0003, "R4 grant");
  endtask

  task automatic t_write_many();
    quiet_read(6, 7, 32'hA000_0007, "R2 b7 p6");
    quiet_read(1, 7, 32'hA000_0007, "R2 b7 p1");
    quiet_read(4, 7, 32'hA000_0007, "R2 b7 p4");
    do_req(1, 0, 7);
    get_msg(1, 1, 7, "R4 order 1st");
    get_msg(1, 4, 7, "R4 order 2nd");
    get_msg(1, 6, 7, "R4 order 3rd");
    send_ack(32'h0);
    send_ack(32'h0);
    chk(!rsp_valid_o, "R4 grant withheld one ack left", 32'(rsp_valid_o), 0);
    send_ack(32'h0);
    get_rsp(1, 0, 32'hA000_0007, "R4 grant many");
  endtask

  task automatic t_read_dirty();
    do_req(0, 1, 3);
    get_msg(0, 5, 3, "R3 recall");
    send_ack(32'hDEAD_0003);
    for (int t = 0; t < 20 && !rsp_valid_o; t++) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid_o && rsp_data_o == 32'hDEAD_0003 && rsp_pid_o == 1, "R9 rsp held",
          rsp_data_o, 32'hDEAD_0003);
    end
    get_rsp(0, 1, 32'hDEAD_0003, "R3 recalled data");
    chk(mem[3] == 32'hDEAD_0003, "R3 memory updated", mem[3], 32'hDEAD_0003);
    do_req(1, 7, 3);
    get_msg(1, 1, 3, "R3 reader is sharer");
    get_msg(1, 5, 3, "R3 old owner is sharer");
    send_ack(32'h0);
    send_ack(32'h0);
    get_rsp(1, 7, 32'hDEAD_0003, "R3 grant after downgrade");
  endtask

  task automatic t_write_dirty();
    int m0;
    do_req(1, 2, 3);
    get_msg(2, 7, 3, "R5 recall-inval");
    send_ack(32'hBEEF_0003);
    get_rsp(1, 2, 32'hBEEF_0003, "R5 grant recalled");
    chk(mem[3] == 32'hBEEF_0003, "R5 memory updated", mem[3], 32'hBEEF_0003);
    m0 = msg_seen;
    do_req(1, 2, 3);
    get_rsp(1, 2, 32'hBEEF_0003, "R6 owner write");
    chk(msg_seen == m0, "R6 owner write silent", 32'(msg_seen - m0), 0);
    quiet_read(2, 3, 32'hBEEF_0003, "R6 owner read");
    do_req(0, 4, 3);
    get_msg(0, 2, 3, "R5 requester sole owner");
    send_ack(32'hCAFE_0003);
    get_rsp(0, 4, 32'hCAFE_0003, "R5 final read");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean_reads();
    t_write_shared();
    t_write_many();
    t_read_dirty();
    t_write_dirty();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule